// File: doc/BRIEF.md
# Transaction-Aware Bus Snoop Responder

This block sits on a shared bus for one processor and answers the bus cycles other agents issue. It holds two local stores: a direct-mapped regular cache and a small fully associative transactional cache whose entries also carry a transaction tag. For each bus cycle it decides whether one of the local stores answers. An answer can supply data or refuse the requester with a BUSY reply. It also decides how the line state of the answering entry changes. A memory responder model is included. It answers every cycle that no cache claims, and it absorbs write-backs and write-throughs.

Line states follow a write-once scheme. The first local write to a shared clean line marks it exclusive-clean and writes the value through to memory. Later writes mark it modified. The transactional cache protects entries owned by a running transaction. When the local transaction status is true, a transactional bus cycle that hits such an entry is refused, except for a transactional shared read of a clean shared entry, which is served. An install port lets the surrounding logic place lines into either store, and a local write port applies processor writes to the regular cache. Every bus cycle produces a single-cycle response strobe one clock later, tagged as cache data, BUSY or memory.

Top module: `tm_snoop_top`

## Requirements
- R1: After synchronous reset, rsp_valid is 0, rsp_kind is 0, both caches hold no lines, and every memory word reads 0.
- R2: A bus cycle sampled with bus_valid=1 on a clock edge yields exactly one response on the next cycle: rsp_valid=1 and rsp_kind nonzero (1=cache data, 2=BUSY, 3=memory). With no bus cycle, rsp_valid=0 and rsp_kind=0. Cycle codes on bus_kind: 0=READ, 1=RFO, 2=WRITE, 3=T_READ, 4=T_RFO.
- R3: In the regular cache, a READ or T_READ that hits a VALID line (state code 1) returns that line's data, and the line stays VALID. The local transaction status does not matter.
- R4: In the regular cache, a READ or T_READ that hits a RESERVED (2) or DIRTY (3) line returns its data and moves the line to VALID.
- R5: In the regular cache, an RFO or T_RFO hit returns the data and invalidates the line. A bus cycle for an address a store does not hold gets no answer from that store.
- R6: When tstatus=0, or the cycle is READ or RFO, the transactional cache behaves like the regular cache but considers only entries tagged NORMAL (tag code 1). Entries tagged XCOMMIT (2) or XABORT (3) are then invisible.
- R7: When tstatus=1, a T_READ that hits a VALID transactional entry of any non-empty tag returns its data and leaves the entry unchanged. If several entries match, the lowest slot number answers.
- R8: When tstatus=1, a T_RFO hit, or a T_READ hit on a RESERVED or DIRTY entry, is answered with BUSY (data 0) and leaves the entry unchanged.
- R9: Memory answers READ, RFO, T_READ and T_RFO with its stored word only when no cache answered. A WRITE stores bus_wdata in memory and is answered as a memory response with data 0.
- R10: When a cache supplies data from a DIRTY line to a READ or T_READ, memory copies that data.
- R11: A local write that hits a VALID regular line makes it RESERVED and writes the value through to memory. A hit on RESERVED or DIRTY makes it DIRTY without updating memory. A local write that misses has no effect.
- R12: At most one source answers a cycle. Precedence is BUSY, then transactional-cache data, then regular-cache data, then memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tstatus | input | 1 | Local transaction status (1 = running transaction not aborted) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_kind | input | 3 | Bus cycle code (0 READ, 1 RFO, 2 WRITE, 3 T_READ, 4 T_RFO) |
| bus_addr | input | ADDR_W | Line address of the bus cycle |
| bus_wdata | input | DATA_W | Data carried by a WRITE cycle |
| inst_en | input | 1 | Install a line this clock |
| inst_to_tx | input | 1 | Install target: 0 regular cache, 1 transactional cache |
| inst_slot | input | clog2(TX_ENTRIES) | Transactional cache slot to install into |
| inst_addr | input | ADDR_W | Address of the installed line |
| inst_state | input | 2 | Line state (0 INVALID, 1 VALID, 2 RESERVED, 3 DIRTY) |
| inst_ttag | input | 2 | Transaction tag (0 EMPTY, 1 NORMAL, 2 XCOMMIT, 3 XABORT) |
| inst_data | input | DATA_W | Data of the installed line |
| lw_en | input | 1 | Local processor write to the regular cache |
| lw_addr | input | ADDR_W | Local write address |
| lw_data | input | DATA_W | Local write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the bus cycle |
| rsp_kind | output | 2 | Response tag (0 none, 1 cache data, 2 BUSY, 3 memory) |
| rsp_data | output | DATA_W | Response data |

## Verification
The hardest thing to see from the ports is a line state change that returns the same data either way. A regular-cache line dropping from DIRTY or RESERVED to VALID is one example. Another is a refused entry staying in place. The stimulus makes such transitions visible through memory. After the snoop read, a local write is issued: it writes through only if the line really became VALID. An RFO then takes the line away, and a final READ falls to memory and exposes the word memory holds. Entries refused with BUSY are probed again with different transaction status values and cycle kinds. This shows they are still resident and still hidden from non-transactional snoops.

// File: rtl/tm_snoop_pkg.sv
package tm_snoop_pkg;

    typedef enum logic [2:0] {
        BK_READ  = 3'd0,
        BK_RFO   = 3'd1,
        BK_WRITE = 3'd2,
        BK_TREAD = 3'd3,
        BK_TRFO  = 3'd4
    } bus_kind_e;

    typedef enum logic [1:0] {
        LS_INVALID  = 2'd0,
        LS_VALID    = 2'd1,
        LS_RESERVED = 2'd2,
        LS_DIRTY    = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        TT_EMPTY   = 2'd0,
        TT_NORMAL  = 2'd1,
        TT_XCOMMIT = 2'd2,
        TT_XABORT  = 2'd3
    } ttag_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_DATA = 2'd1,
        RK_BUSY = 2'd2,
        RK_MEM  = 2'd3
    } rsp_kind_e;

    // Shared-copy requests (plain or transactional)
    function automatic logic wants_shared(bus_kind_e k);
        return (k == BK_READ) || (k == BK_TREAD);
    endfunction

    function automatic logic is_txn_cycle(bus_kind_e k);
        return (k == BK_TREAD) || (k == BK_TRFO);
    endfunction

    // State a snooped line takes after supplying data
    function automatic line_st_e after_snoop(bus_kind_e k);
        return wants_shared(k) ? LS_VALID : LS_INVALID;
    endfunction

    // Memory picks up modified data handed to a shared reader
    function automatic logic gives_snarf(line_st_e s, bus_kind_e k);
        return (s == LS_DIRTY) && wants_shared(k);
    endfunction

endpackage

// File: rtl/tm_reg_snoop.sv
module tm_reg_snoop
    import tm_snoop_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_en,
    input  bus_kind_e         snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr,
    input  line_st_e          ins_state,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              lw_en,
    input  logic [ADDR_W-1:0] lw_addr,
    input  logic [DATA_W-1:0] lw_data,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              snarf,
    output logic              wt_en,
    output logic [ADDR_W-1:0] wt_addr,
    output logic [DATA_W-1:0] wt_data
);
    localparam int IDX_W = $clog2(LINES);

    line_st_e          st_q  [LINES];
    logic [ADDR_W-1:0] tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    logic [IDX_W-1:0] s_idx, l_idx, i_idx;
    logic             l_hit;

    assign s_idx = snp_addr[IDX_W-1:0];
    assign l_idx = lw_addr[IDX_W-1:0];
    assign i_idx = ins_addr[IDX_W-1:0];

    always_comb begin
        hit      = snp_en && (snp_kind != BK_WRITE) &&
                   (st_q[s_idx] != LS_INVALID) && (tag_q[s_idx] == snp_addr);
        hit_data = dat_q[s_idx];
        snarf    = hit && gives_snarf(st_q[s_idx], snp_kind);
        l_hit    = lw_en && (st_q[l_idx] != LS_INVALID) && (tag_q[l_idx] == lw_addr);
        wt_en    = l_hit && (st_q[l_idx] == LS_VALID);
        wt_addr  = lw_addr;
        wt_data  = lw_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LS_INVALID;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (ins_en) begin
            st_q[i_idx]  <= ins_state;
            tag_q[i_idx] <= ins_addr;
            dat_q[i_idx] <= ins_data;
        end else begin
            if (hit)
                st_q[s_idx] <= after_snoop(snp_kind);
            if (l_hit) begin
                st_q[l_idx]  <= (st_q[l_idx] == LS_VALID) ? LS_RESERVED : LS_DIRTY;
                dat_q[l_idx] <= lw_data;
            end
        end
    end

endmodule

// File: rtl/tm_txn_snoop.sv
module tm_txn_snoop
    import tm_snoop_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 8,
    parameter int ENTRIES = 4,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tstatus,
    input  logic              snp_en,
    input  bus_kind_e         snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              ins_en,
    input  logic [SLOT_W-1:0] ins_slot,
    input  logic [ADDR_W-1:0] ins_addr,
    input  line_st_e          ins_state,
    input  ttag_e             ins_ttag,
    input  logic [DATA_W-1:0] ins_data,
    output logic              hit,
    output logic              busy,
    output logic [DATA_W-1:0] hit_data,
    output logic              snarf
);
    line_st_e          st_q  [ENTRIES];
    ttag_e             tt_q  [ENTRIES];
    logic [ADDR_W-1:0] adr_q [ENTRIES];
    logic [DATA_W-1:0] dat_q [ENTRIES];

    logic               txmode;
    logic [ENTRIES-1:0] eligible;
    logic               found;
    logic [SLOT_W-1:0]  sel;

    assign txmode = tstatus && is_txn_cycle(snp_kind);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        logic present;
        assign present = snp_en && (snp_kind != BK_WRITE) &&
                         (st_q[g] != LS_INVALID) && (tt_q[g] != TT_EMPTY) &&
                         (adr_q[g] == snp_addr);
        assign eligible[g] = txmode ? present : (present && (tt_q[g] == TT_NORMAL));
    end

    // Lowest matching slot wins
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                sel   = SLOT_W'(i);
            end
        end
        hit      = found && (!txmode || ((snp_kind == BK_TREAD) && (st_q[sel] == LS_VALID)));
        busy     = found && txmode && !((snp_kind == BK_TREAD) && (st_q[sel] == LS_VALID));
        hit_data = dat_q[sel];
        snarf    = hit && !txmode && gives_snarf(st_q[sel], snp_kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]  <= LS_INVALID;
                tt_q[i]  <= TT_EMPTY;
                adr_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else if (ins_en) begin
            st_q[ins_slot]  <= ins_state;
            tt_q[ins_slot]  <= ins_ttag;
            adr_q[ins_slot] <= ins_addr;
            dat_q[ins_slot] <= ins_data;
        end else if (hit && !txmode) begin
            st_q[sel] <= after_snoop(snp_kind);
        end
    end

endmodule

// File: rtl/tm_mem_responder.sv
module tm_mem_responder
    import tm_snoop_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  bus_kind_e         bus_kind,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              claimed,
    input  logic              snarf_en,
    input  logic [DATA_W-1:0] snarf_data,
    input  logic              wt_en,
    input  logic [ADDR_W-1:0] wt_addr,
    input  logic [DATA_W-1:0] wt_data,
    output logic              answer,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    assign answer  = bus_en && !claimed;
    assign rd_data = (bus_kind == BK_WRITE) ? '0 : mem_q[bus_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                mem_q[i] <= '0;
        end else begin
            if (wt_en)
                mem_q[wt_addr] <= wt_data;
            if (bus_en && (bus_kind == BK_WRITE))
                mem_q[bus_addr] <= bus_wdata;
            else if (snarf_en)
                mem_q[bus_addr] <= snarf_data;
        end
    end

endmodule

// File: rtl/tm_snoop_top.sv
module tm_snoop_top
    import tm_snoop_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter int REG_LINES  = 4,
    parameter int TX_ENTRIES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tstatus,
    input  logic                          bus_valid,
    input  logic [2:0]                    bus_kind,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          inst_en,
    input  logic                          inst_to_tx,
    input  logic [$clog2(TX_ENTRIES)-1:0] inst_slot,
    input  logic [ADDR_W-1:0]             inst_addr,
    input  logic [1:0]                    inst_state,
    input  logic [1:0]                    inst_ttag,
    input  logic [DATA_W-1:0]             inst_data,
    input  logic                          lw_en,
    input  logic [ADDR_W-1:0]             lw_addr,
    input  logic [DATA_W-1:0]             lw_data,
    output logic                          rsp_valid,
    output logic [1:0]                    rsp_kind,
    output logic [DATA_W-1:0]             rsp_data
);
    bus_kind_e kind;
    assign kind = bus_kind_e'(bus_kind);

    logic              r_hit, r_snarf, r_wt;
    logic [DATA_W-1:0] r_data, r_wt_data;
    logic [ADDR_W-1:0] r_wt_addr;
    logic              t_hit, t_busy, t_snarf;
    logic [DATA_W-1:0] t_data;
    logic              m_answer;
    logic [DATA_W-1:0] m_data;
    logic              snarf_en;
    logic [DATA_W-1:0] snarf_data;

    rsp_kind_e         nxt_kind;
    logic [DATA_W-1:0] nxt_data;

    tm_reg_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(REG_LINES)) u_reg (
        .clk(clk), .rst(rst),
        .snp_en(bus_valid), .snp_kind(kind), .snp_addr(bus_addr),
        .ins_en(inst_en && !inst_to_tx), .ins_addr(inst_addr),
        .ins_state(line_st_e'(inst_state)), .ins_data(inst_data),
        .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
        .hit(r_hit), .hit_data(r_data), .snarf(r_snarf),
        .wt_en(r_wt), .wt_addr(r_wt_addr), .wt_data(r_wt_data)
    );

    tm_txn_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(TX_ENTRIES)) u_txn (
        .clk(clk), .rst(rst), .tstatus(tstatus),
        .snp_en(bus_valid), .snp_kind(kind), .snp_addr(bus_addr),
        .ins_en(inst_en && inst_to_tx), .ins_slot(inst_slot), .ins_addr(inst_addr),
        .ins_state(line_st_e'(inst_state)), .ins_ttag(ttag_e'(inst_ttag)),
        .ins_data(inst_data),
        .hit(t_hit), .busy(t_busy), .hit_data(t_data), .snarf(t_snarf)
    );

    // Data handed out from a modified line is mirrored into memory
    assign snarf_en   = !t_busy && (t_snarf || (!t_hit && r_snarf));
    assign snarf_data = t_snarf ? t_data : r_data;

    tm_mem_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst(rst),
        .bus_en(bus_valid), .bus_kind(kind), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .claimed(t_busy || t_hit || r_hit),
        .snarf_en(snarf_en), .snarf_data(snarf_data),
        .wt_en(r_wt), .wt_addr(r_wt_addr), .wt_data(r_wt_data),
        .answer(m_answer), .rd_data(m_data)
    );

    // Response arbitration: refusal, then transactional data, then regular, then memory
    always_comb begin
        nxt_kind = RK_NONE;
        nxt_data = '0;
        if (bus_valid) begin
            if (t_busy) begin
                nxt_kind = RK_BUSY;
            end else if (t_hit) begin
                nxt_kind = RK_DATA;
                nxt_data = t_data;
            end else if (r_hit) begin
                nxt_kind = RK_DATA;
                nxt_data = r_data;
            end else if (m_answer) begin
                nxt_kind = RK_MEM;
                nxt_data = m_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= RK_NONE;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (nxt_kind != RK_NONE);
            rsp_kind  <= nxt_kind;
            rsp_data  <= nxt_data;
        end
    end

endmodule

// File: rtl/tm_snoop_checker.sv
module tm_snoop_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tstatus,
    input logic              bus_valid,
    input logic [2:0]        bus_kind,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic [DATA_W-1:0] rsp_data
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> rsp_valid);

    assert_rsp_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(bus_valid));

    assert_rsp_tagged_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == (rsp_kind != 2'd0));

    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_kind == 2'd2) |-> ($past(tstatus) &&
            (($past(bus_kind) == 3'd3) || ($past(bus_kind) == 3'd4))));

    assert_write_to_mem_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(bus_kind) == 3'd2)) |-> (rsp_kind == 2'd3));

    assert_busy_no_data_R12: assert property (@(posedge clk) disable iff (rst)
        (rsp_kind == 2'd2) |-> (rsp_data == '0));

endmodule

bind tm_snoop_top tm_snoop_checker #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst(rst), .tstatus(tstatus), .bus_valid(bus_valid),
    .bus_kind(bus_kind), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data)
);

// File: tb/test_tm_snoop_top.sv
`timescale 1ns/1ps
module test_tm_snoop_top;

    localparam logic [2:0] READ = 3'd0, RFO = 3'd1, WRITE = 3'd2, TREAD = 3'd3, TRFO = 3'd4;
    localparam logic [1:0] ST_V = 2'd1, ST_R = 2'd2, ST_D = 2'd3;
    localparam logic [1:0] TG_N = 2'd1, TG_C = 2'd2, TG_A = 2'd3;
    localparam logic [1:0] K_DATA = 2'd1, K_BUSY = 2'd2, K_MEM = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tstatus = 1'b0;
    logic       bus_valid = 1'b0;
    logic [2:0] bus_kind = '0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       inst_en = 1'b0;
    logic       inst_to_tx = 1'b0;
    logic [1:0] inst_slot = '0;
    logic [4:0] inst_addr = '0;
    logic [1:0] inst_state = '0;
    logic [1:0] inst_ttag = '0;
    logic [7:0] inst_data = '0;
    logic       lw_en = 1'b0;
    logic [4:0] lw_addr = '0;
    logic [7:0] lw_data = '0;
    logic       rsp_valid;
    logic [1:0] rsp_kind;
    logic [7:0] rsp_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    tm_snoop_top i_tm_snoop_top (
        .clk(clk), .rst(rst), .tstatus(tstatus),
        .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .inst_en(inst_en), .inst_to_tx(inst_to_tx), .inst_slot(inst_slot),
        .inst_addr(inst_addr), .inst_state(inst_state), .inst_ttag(inst_ttag),
        .inst_data(inst_data),
        .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data)
    );

    // {kind, addr, wdata, tstatus, expected kind, expected data}
    localparam int NVEC = 8;
    localparam logic [26:0] VEC [NVEC] = '{
        {WRITE, 5'h05, 8'h3C, 1'b0, K_MEM, 8'h00},
        {READ,  5'h05, 8'h00, 1'b0, K_MEM, 8'h3C},
        {TREAD, 5'h05, 8'h00, 1'b1, K_MEM, 8'h3C},
        {RFO,   5'h07, 8'h00, 1'b0, K_MEM, 8'h00},
        {WRITE, 5'h07, 8'h81, 1'b0, K_MEM, 8'h00},
        {TRFO,  5'h07, 8'h00, 1'b1, K_MEM, 8'h81},
        {WRITE, 5'h1C, 8'hF0, 1'b1, K_MEM, 8'h00},
        {TREAD, 5'h1C, 8'h00, 1'b0, K_MEM, 8'hF0}
    };

    task automatic check(input string req, input logic [1:0] ek, input logic [7:0] ed);
        logic ev;
        ev = (ek != 2'd0);
        n_checks++;
        if (rsp_valid !== ev || rsp_kind !== ek || rsp_data !== ed) begin
            n_fails++;
            $display("FAIL %s: valid=%0b kind=%0d data=%h expected valid=%0b kind=%0d data=%h",
                     req, rsp_valid, rsp_kind, rsp_data, ev, ek, ed);
        end
    endtask

    task automatic bus(input logic [2:0] k, input logic [4:0] a, input logic [7:0] d,
                       input logic ts);
        @(negedge clk);
        bus_valid = 1'b1; bus_kind = k; bus_addr = a; bus_wdata = d; tstatus = ts;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic snoop(input string req, input logic [2:0] k, input logic [4:0] a,
                         input logic ts, input logic [1:0] ek, input logic [7:0] ed);
        bus(k, a, 8'h00, ts);
        check(req, ek, ed);
    endtask

    task automatic put_reg(input logic [4:0] a, input logic [1:0] st, input logic [7:0] d);
        @(negedge clk);
        inst_en = 1'b1; inst_to_tx = 1'b0; inst_addr = a; inst_state = st; inst_data = d;
        @(negedge clk);
        inst_en = 1'b0;
    endtask

    task automatic put_tx(input logic [1:0] slot, input logic [4:0] a, input logic [1:0] st,
                          input logic [1:0] tg, input logic [7:0] d);
        @(negedge clk);
        inst_en = 1'b1; inst_to_tx = 1'b1; inst_slot = slot; inst_addr = a;
        inst_state = st; inst_ttag = tg; inst_data = d;
        @(negedge clk);
        inst_en = 1'b0;
    endtask

    task automatic lwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        lw_en = 1'b1; lw_addr = a; lw_data = d;
        @(negedge clk);
        lw_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: valid=%0b kind=%0d data=%h expected run completion",
                 rsp_valid, rsp_kind, rsp_data);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet response after reset, memory cleared
        check("R1 reset", 2'd0, 8'h00);
        snoop("R1 memory cleared", READ, 5'h03, 1'b0, K_MEM, 8'h00);
        // R2: strobe lasts one cycle
        @(negedge clk);
        check("R2 single strobe", 2'd0, 8'h00);

        // R9: memory-only vectors
        for (int i = 0; i < NVEC; i++) begin
            bus(VEC[i][26:24], VEC[i][23:19], VEC[i][18:11], VEC[i][10]);
            check($sformatf("R9 vector %0d", i), VEC[i][9:8], VEC[i][7:0]);
        end

        // R3: shared hit on VALID keeps the line
        put_reg(5'h01, ST_V, 8'h11);
        snoop("R3 read valid", READ, 5'h01, 1'b0, K_DATA, 8'h11);
        snoop("R3 tread valid kept", TREAD, 5'h01, 1'b1, K_DATA, 8'h11);

        // R4: DIRTY drops to VALID, proven by a later write-through
        put_reg(5'h02, ST_D, 8'h22);
        snoop("R4 read dirty", READ, 5'h02, 1'b0, K_DATA, 8'h22);
        lwrite(5'h02, 8'h55);
        snoop("R4 rfo after write", RFO, 5'h02, 1'b0, K_DATA, 8'h55);
        snoop("R4 write-through seen", READ, 5'h02, 1'b0, K_MEM, 8'h55);

        // R4: RESERVED drops to VALID
        put_reg(5'h0B, ST_R, 8'h33);
        snoop("R4 tread reserved", TREAD, 5'h0B, 1'b0, K_DATA, 8'h33);
        lwrite(5'h0B, 8'h44);
        snoop("R4 rfo reserved line", RFO, 5'h0B, 1'b0, K_DATA, 8'h44);
        snoop("R4 reserved became valid", READ, 5'h0B, 1'b0, K_MEM, 8'h44);

        // R10: memory copies dirty data given to a reader
        put_reg(5'h06, ST_D, 8'h66);
        snoop("R10 tread dirty", TREAD, 5'h06, 1'b0, K_DATA, 8'h66);
        snoop("R10 rfo", RFO, 5'h06, 1'b0, K_DATA, 8'h66);
        snoop("R10 memory updated", READ, 5'h06, 1'b0, K_MEM, 8'h66);

        // R5: exclusive request invalidates
        put_reg(5'h08, ST_V, 8'h88);
        snoop("R5 trfo hit", TRFO, 5'h08, 1'b0, K_DATA, 8'h88);
        snoop("R5 line gone", READ, 5'h08, 1'b0, K_MEM, 8'h00);

        // R11: write-once sequence and ignored miss
        put_reg(5'h09, ST_V, 8'h90);
        lwrite(5'h09, 8'hA1);
        lwrite(5'h09, 8'hA2);
        snoop("R11 latest data", RFO, 5'h09, 1'b0, K_DATA, 8'hA2);
        snoop("R11 only first write through", READ, 5'h09, 1'b0, K_MEM, 8'hA1);
        lwrite(5'h0D, 8'hB0);
        snoop("R11 miss ignored", READ, 5'h0D, 1'b0, K_MEM, 8'h00);

        // R6/R8/R12: NORMAL entry in the transactional cache
        put_tx(2'd2, 5'h14, ST_D, TG_N, 8'hD4);
        snoop("R6 read normal", READ, 5'h14, 1'b1, K_DATA, 8'hD4);
        snoop("R8 trfo refused", TRFO, 5'h14, 1'b1, K_BUSY, 8'h00);
        snoop("R6 trfo inactive", TRFO, 5'h14, 1'b0, K_DATA, 8'hD4);
        snoop("R10 tx dirty copied", TREAD, 5'h14, 1'b1, K_MEM, 8'hD4);

        // R8/R6: XABORT entry, RESERVED
        put_tx(2'd3, 5'h16, ST_R, TG_A, 8'hE6);
        snoop("R8 tread reserved busy", TREAD, 5'h16, 1'b1, K_BUSY, 8'h00);
        snoop("R8 still held", TREAD, 5'h16, 1'b1, K_BUSY, 8'h00);
        snoop("R6 xabort hidden inactive", TREAD, 5'h16, 1'b0, K_MEM, 8'h00);
        snoop("R6 xabort hidden plain read", READ, 5'h16, 1'b1, K_MEM, 8'h00);
        snoop("R12 busy over memory", TRFO, 5'h16, 1'b1, K_BUSY, 8'h00);

        // R7: VALID entry served to T_READ, lowest slot wins
        put_tx(2'd1, 5'h12, ST_V, TG_A, 8'hC9);
        put_tx(2'd0, 5'h12, ST_V, TG_C, 8'hC1);
        snoop("R7 tread valid", TREAD, 5'h12, 1'b1, K_DATA, 8'hC1);
        snoop("R7 unchanged", TREAD, 5'h12, 1'b1, K_DATA, 8'hC1);
        snoop("R8 trfo on valid", TRFO, 5'h12, 1'b1, K_BUSY, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule